// File: doc/BRIEF.md
# Rate-Configurable TDM Stream Multiplexer

This block places four logical serial streams of eight-bit channel timeslots onto four physical serial pins. A two-bit rate mode chooses how they are combined: each stream on its own pin at the base rate, pairs of streams interleaved on two pins at twice the rate, or all four interleaved on one pin at four times the rate. Interleaving is always channel by channel. The line clock runs at the bit rate of the selected mode, and an active-high frame pulse marks the first bit of slot 0.

On the transmit side, the block announces at the start of every slot which stream and channel each pin needs. It takes the byte offered for that pin in the same cycle and shifts it out serially. On the receive side, it deserializes each pin and returns every completed byte with the stream and channel that the slot belonged to. Pins that carry nothing in the current mode, and every pin in the reserved mode, are held high.

Top module: `tdm_stream_mux`

## Requirements
- R1: In mode 0 (`mode_i` = 00), pin p carries stream p and slot s carries channel s. There are 32 slots per frame, and a frame is 256 clocks.
- R2: In mode 1 (01), pin 0 carries streams 0 and 1 and pin 2 carries streams 2 and 3. Slot s on pin 0 holds stream (s mod 2), channel s/2. On pin 2 it holds stream 2 + (s mod 2), channel s/2. A frame is 512 clocks.
- R3: In mode 2 (10), pin 0 carries all four streams. Slot s holds stream (s mod 4), channel s/4. A frame is 1024 clocks.
- R4: Each slot is 8 bits, sent most significant bit first. The bit with frame index k is driven on `tx_pin_o` one clock after the cycle in which the bit counter is k.
- R5: The cycle in which `frame_i` is high is bit 0 of slot 0, even mid-frame. With no pulse, the counter wraps on its own at the frame length of the active mode.
- R6: Any pin that carries no stream in the active mode drives 1, receives no byte and gets address 0.
- R7: Mode 3 (11) is reserved. All pins drive 1, no received byte is reported and `tx_load_o` stays low.
- R8: `mode_i` is sampled only in a cycle where `frame_i` is high. A change written mid-frame has no effect until the next pulse.
- R9: A byte received on pin p is reported on lane p, with `rx_valid_o[p]` high for one clock in the cycle after its last bit. It comes with its stream (2 bits) and channel (5 bits). The first bit received is the byte's MSB.
- R10: During reset and until the first frame pulse, all pins drive 1, no valid strobe is raised and the block behaves as in mode 3.
- R11: In every bit-0 cycle of a non-reserved mode, `tx_load_o` is high. Lane p of `tx_addr_o` (bits 7p+6..7p) then holds {stream[1:0], channel[4:0]} for pin p, and the byte on `tx_byte_i` bits 8p+7..8p is taken in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Line bit clock at the active rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_i | input | 1 | Frame pulse, high during bit 0 of slot 0 |
| mode_i | input | 2 | Rate mode, sampled on the frame pulse |
| tx_load_o | output | 1 | Slot start: transmit bytes are taken this cycle |
| tx_addr_o | output | 28 | Per-pin {stream, channel} request, 7 bits per lane |
| tx_byte_i | input | 32 | Per-pin transmit byte, 8 bits per lane |
| tx_pin_o | output | 4 | Serial transmit pins |
| rx_pin_i | input | 4 | Serial receive pins |
| rx_valid_o | output | 4 | Per-lane received-byte strobe |
| rx_byte_o | output | 32 | Per-lane received byte |
| rx_stream_o | output | 8 | Per-lane stream tag, 2 bits per lane |
| rx_chan_o | output | 20 | Per-lane channel tag, 5 bits per lane |

## Verification
Transmit bytes are a function of stream and channel, and the function changes between test phases, so a byte sent to the wrong slot or pin shows up as a bit mismatch. Receive data uses a second function of the same tag, which catches swapped tags and wrong deserialization order. The interleaving orders of the three rates are each run over full frames. A mode write in the middle of a frame shows whether the mapping switches early. A stretch with no frame pulse separates the free-running wrap from pulse-driven restart, and a pulse that lands in the middle of a slot checks restart alignment. Reserved-mode runs with noise on the receive pins confirm that the pins stay idle and that nothing is reported.

// File: rtl/tdm_mux_pkg.sv
package tdm_mux_pkg;
  localparam int LANES      = 4;
  localparam int SLOT_BITS  = 8;
  localparam int BASE_CH    = 32;
  localparam int MAX_FACTOR = 4;
  localparam int BIT_W      = $clog2(SLOT_BITS);
  localparam int CH_W       = $clog2(BASE_CH);
  localparam int ST_W       = $clog2(LANES);
  localparam int BASE_LEN   = SLOT_BITS * BASE_CH;
  localparam int POS_W      = $clog2(BASE_LEN * MAX_FACTOR);
  localparam int SLOT_W     = POS_W - BIT_W;
  localparam int TAG_W      = ST_W + CH_W;

  typedef enum logic [1:0] {
    MODE_2M   = 2'b00,
    MODE_4M   = 2'b01,
    MODE_8M   = 2'b10,
    MODE_RSVD = 2'b11
  } rate_mode_e;

  typedef struct packed {
    logic            used;
    logic [ST_W-1:0] stream;
    logic [CH_W-1:0] chan;
  } slot_tag_t;

  // Clocks per frame for a given rate mode
  function automatic logic [POS_W:0] frame_len(rate_mode_e m);
    case (m)
      MODE_4M: return (POS_W+1)'(BASE_LEN * 2);
      MODE_8M: return (POS_W+1)'(BASE_LEN * 4);
      default: return (POS_W+1)'(BASE_LEN);
    endcase
  endfunction

  // Which stream/channel a physical lane carries in a given slot
  function automatic slot_tag_t slot_map(rate_mode_e m, logic [ST_W-1:0] lane,
                                         logic [SLOT_W-1:0] slot);
    slot_tag_t t;
    t = '0;
    case (m)
      MODE_2M: begin
        t.used   = 1'b1;
        t.stream = lane;
        t.chan   = slot[CH_W-1:0];
      end
      MODE_4M: begin
        t.used   = ~lane[0];
        t.stream = {lane[1], slot[0]};
        t.chan   = slot[CH_W:1];
      end
      MODE_8M: begin
        t.used   = (lane == '0);
        t.stream = slot[1:0];
        t.chan   = slot[CH_W+1:2];
      end
      default: t = '0;
    endcase
    return t;
  endfunction
endpackage

// File: rtl/tdm_frame_timer.sv
module tdm_frame_timer
  import tdm_mux_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_i,
  input  rate_mode_e        mode_i,
  output rate_mode_e        cur_mode_o,
  output logic [BIT_W-1:0]  bit_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] cur_pos;
  rate_mode_e       mode_q;
  rate_mode_e       cur_mode;
  logic             wrap_w;

  // The pulse cycle is position 0 and also adopts the requested mode
  assign cur_pos  = frame_i ? '0 : pos_q;
  assign cur_mode = frame_i ? mode_i : mode_q;
  assign wrap_w   = ({1'b0, cur_pos} == frame_len(cur_mode) - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      mode_q <= MODE_RSVD;
    end else begin
      pos_q  <= wrap_w ? '0 : cur_pos + 1'b1;
      mode_q <= cur_mode;
    end
  end

  assign cur_mode_o = cur_mode;
  assign bit_o      = cur_pos[BIT_W-1:0];
  assign slot_o     = cur_pos[POS_W-1:BIT_W];

  AST_POS_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, pos_q} < frame_len(mode_q)); // R5
  AST_PULSE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_i |=> (pos_q == POS_W'(1))); // R5
  AST_MODE_FRAME_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_i |=> $stable(mode_q)); // R8
endmodule

// File: rtl/tdm_tx_lane.sv
module tdm_tx_lane
  import tdm_mux_pkg::*;
#(
  parameter int LANE_ID = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rate_mode_e           cur_mode_i,
  input  logic [BIT_W-1:0]     bit_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [SLOT_BITS-1:0] byte_i,
  output slot_tag_t            tag_o,
  output logic                 pin_o
);
  slot_tag_t            tag_w;
  logic                 slot_start_w;
  logic [SLOT_BITS-1:0] sh_q;
  logic                 pin_q;

  assign tag_w        = slot_map(cur_mode_i, ST_W'(LANE_ID), slot_i);
  assign slot_start_w = (bit_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b1;
      sh_q  <= '1;
    end else if (slot_start_w) begin
      pin_q <= tag_w.used ? byte_i[SLOT_BITS-1] : 1'b1;
      sh_q  <= tag_w.used ? {byte_i[SLOT_BITS-2:0], 1'b1} : '1;
    end else begin
      pin_q <= sh_q[SLOT_BITS-1];
      sh_q  <= {sh_q[SLOT_BITS-2:0], 1'b1};
    end
  end

  assign tag_o = tag_w;
  assign pin_o = pin_q;

  AST_IDLE_LANE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start_w && !tag_w.used) |=> pin_q); // R6
  AST_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_start_w && tag_w.used) |=> (pin_q == $past(byte_i[SLOT_BITS-1]))); // R4
endmodule

// File: rtl/tdm_rx_lane.sv
module tdm_rx_lane
  import tdm_mux_pkg::*;
#(
  parameter int LANE_ID = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  rate_mode_e           cur_mode_i,
  input  logic [BIT_W-1:0]     bit_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic                 pin_i,
  output logic                 valid_o,
  output logic [SLOT_BITS-1:0] byte_o,
  output logic [ST_W-1:0]      stream_o,
  output logic [CH_W-1:0]      chan_o
);
  slot_tag_t            tag_w;
  logic                 last_bit_w;
  logic [SLOT_BITS-2:0] sh_q;
  logic                 valid_q;
  logic [SLOT_BITS-1:0] byte_q;
  logic [ST_W-1:0]      stream_q;
  logic [CH_W-1:0]      chan_q;

  assign tag_w      = slot_map(cur_mode_i, ST_W'(LANE_ID), slot_i);
  assign last_bit_w = (bit_i == BIT_W'(SLOT_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '0;
      valid_q  <= 1'b0;
      byte_q   <= '0;
      stream_q <= '0;
      chan_q   <= '0;
    end else begin
      sh_q    <= {sh_q[SLOT_BITS-3:0], pin_i};
      valid_q <= last_bit_w && tag_w.used;
      if (last_bit_w && tag_w.used) begin
        byte_q   <= {sh_q, pin_i};
        stream_q <= tag_w.stream;
        chan_q   <= tag_w.chan;
      end
    end
  end

  assign valid_o  = valid_q;
  assign byte_o   = byte_q;
  assign stream_o = stream_q;
  assign chan_o   = chan_q;

  AST_RX_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(last_bit_w)); // R9
  AST_RX_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> ($past(cur_mode_i) != MODE_RSVD)); // R7
endmodule

// File: rtl/tdm_stream_mux.sv
module tdm_stream_mux
  import tdm_mux_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_i,
  input  logic [1:0]                 mode_i,
  output logic                       tx_load_o,
  output logic [LANES*TAG_W-1:0]     tx_addr_o,
  input  logic [LANES*SLOT_BITS-1:0] tx_byte_i,
  output logic [LANES-1:0]           tx_pin_o,
  input  logic [LANES-1:0]           rx_pin_i,
  output logic [LANES-1:0]           rx_valid_o,
  output logic [LANES*SLOT_BITS-1:0] rx_byte_o,
  output logic [LANES*ST_W-1:0]      rx_stream_o,
  output logic [LANES*CH_W-1:0]      rx_chan_o
);
  rate_mode_e        cur_mode;
  logic [BIT_W-1:0]  bit_idx;
  logic [SLOT_W-1:0] slot_idx;
  logic [LANES-1:0]  lane_used;

  tdm_frame_timer u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_i    (frame_i),
    .mode_i     (rate_mode_e'(mode_i)),
    .cur_mode_o (cur_mode),
    .bit_o      (bit_idx),
    .slot_o     (slot_idx)
  );

  assign tx_load_o = (bit_idx == '0) && (cur_mode != MODE_RSVD);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    slot_tag_t tx_tag;

    tdm_tx_lane #(.LANE_ID(g)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur_mode_i (cur_mode),
      .bit_i      (bit_idx),
      .slot_i     (slot_idx),
      .byte_i     (tx_byte_i[SLOT_BITS*g +: SLOT_BITS]),
      .tag_o      (tx_tag),
      .pin_o      (tx_pin_o[g])
    );

    assign lane_used[g] = tx_tag.used;
    assign tx_addr_o[TAG_W*g +: TAG_W] = tx_tag.used ? {tx_tag.stream, tx_tag.chan} : '0;

    tdm_rx_lane #(.LANE_ID(g)) u_rx (
      .clk        (clk),
      .rst_n      (rst_n),
      .cur_mode_i (cur_mode),
      .bit_i      (bit_idx),
      .slot_i     (slot_idx),
      .pin_i      (rx_pin_i[g]),
      .valid_o    (rx_valid_o[g]),
      .byte_o     (rx_byte_o[SLOT_BITS*g +: SLOT_BITS]),
      .stream_o   (rx_stream_o[ST_W*g +: ST_W]),
      .chan_o     (rx_chan_o[CH_W*g +: CH_W])
    );
  end

  AST_SINGLE_LANE_8M: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_8M) |-> (lane_used == LANES'(1))); // R3
  AST_TWO_LANES_4M: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_4M) |-> ($countones(lane_used) == 2)); // R2
  AST_RSVD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_RSVD) |=> (rx_valid_o == '0)); // R7
endmodule

// File: tb/sim_tdm_stream_mux.sv
`timescale 1ns/1ps
module sim_tdm_stream_mux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic        tx_load_o;
  logic [27:0] tx_addr_o;
  logic [31:0] tx_byte_i;
  logic [3:0]  tx_pin_o;
  logic [3:0]  rx_pin_i = 4'h0;
  logic [3:0]  rx_valid_o;
  logic [31:0] rx_byte_o;
  logic [7:0]  rx_stream_o;
  logic [19:0] rx_chan_o;

  always #2 clk = ~clk;

  tdm_stream_mux u0 (.*);

  int    n_cmp = 0;
  int    n_bad = 0;
  int    salt = 0;
  string phase = "R10 reset";

  // Model state and per-lane expectations for the next edge
  int    m_pos = 0, m_mode = 3;
  int    cm, cp, slotn, bitn;
  int    lu[4], ls[4], lc[4];
  int    e_pin[4], e_v[4], e_b[4], e_s[4], e_c[4];
  string e_tag[4];

  function automatic int txpat(int s, int c);
    return (s * 61 + c * 13 + salt) & 255;
  endfunction
  function automatic int rxpat(int s, int c);
    return ((s * 29 + c * 11 + 7 + salt) & 255) ^ 8'h5A;
  endfunction
  function automatic int flen(int m);
    return (m == 3) ? 256 : 256 * (1 << m);
  endfunction

  task automatic lane_map(int m, int p, int slot, output int used, output int s, output int c);
    int k;
    used = 0; s = 0; c = 0;
    if (m != 3) begin
      k = 1 << m;
      used = (p % k == 0) ? 1 : 0;
      s = p + slot % k;
      c = slot / k;
    end
  endtask

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d [%s] t=%0t", req, act, exp, phase, $time);
    end
  endtask

  // Bytes offered in response to the per-lane request
  always_comb begin
    for (int p = 0; p < 4; p++)
      tx_byte_i[8*p +: 8] = 8'(txpat(int'(tx_addr_o[7*p+5 +: 2]), int'(tx_addr_o[7*p +: 5])));
  end

  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      m_pos = 0; m_mode = 3; rx_pin_i = 4'h0;
      #1;
      for (int p = 0; p < 4; p++) begin
        chk("R10 pin idle in reset", int'(tx_pin_o[p]), 1);
        chk("R10 no strobe in reset", int'(rx_valid_o[p]), 0);
        e_pin[p] = 1; e_v[p] = 0; e_tag[p] = "R10";
      end
    end else begin
      cm = frame_i ? int'(mode_i) : m_mode;
      cp = frame_i ? 0 : m_pos;
      slotn = cp / 8; bitn = cp % 8;
      for (int p = 0; p < 4; p++) begin
        lane_map(cm, p, slotn, lu[p], ls[p], lc[p]);
        rx_pin_i[p] = lu[p] ? 1'((rxpat(ls[p], lc[p]) >> (7 - bitn)) & 1) : 1'(((cp * 7 + p) % 3) == 0);
      end
      #1;
      for (int p = 0; p < 4; p++) begin
        chk({e_tag[p], " pin"}, int'(tx_pin_o[p]), e_pin[p]);
        chk({e_tag[p], " R9 strobe"}, int'(rx_valid_o[p]), e_v[p]);
        if (e_v[p] != 0) begin
          chk("R9 rx byte", int'(rx_byte_o[8*p +: 8]), e_b[p]);
          chk("R9 rx stream", int'(rx_stream_o[2*p +: 2]), e_s[p]);
          chk("R9 rx channel", int'(rx_chan_o[5*p +: 5]), e_c[p]);
        end
      end
      chk("R11 R7 load strobe", int'(tx_load_o), (bitn == 0 && cm != 3) ? 1 : 0);
      if (bitn == 0) begin
        for (int p = 0; p < 4; p++)
          chk("R11 R6 request address", int'(tx_addr_o[7*p +: 7]), lu[p] ? (ls[p] * 32 + lc[p]) : 0);
      end
      for (int p = 0; p < 4; p++) begin
        e_pin[p] = lu[p] ? ((txpat(ls[p], lc[p]) >> (7 - bitn)) & 1) : 1;
        e_v[p] = (lu[p] != 0 && bitn == 7) ? 1 : 0;
        e_b[p] = rxpat(ls[p], lc[p]);
        e_s[p] = ls[p]; e_c[p] = lc[p];
        if (cm == 3) e_tag[p] = "R7";
        else if (lu[p] == 0) e_tag[p] = "R6";
        else if (cm == 0) e_tag[p] = "R1 R4";
        else if (cm == 1) e_tag[p] = "R2 R4";
        else e_tag[p] = "R3 R4";
      end
      m_mode = cm;
      m_pos = (cp == flen(cm) - 1) ? 0 : cp + 1;
    end
  end

  task automatic run_frames(int m, int n);
    for (int f = 0; f < n; f++) begin
      frame_i = 1'b1; mode_i = 2'(m);
      @(negedge clk);
      frame_i = 1'b0;
      repeat (flen(m) - 1) @(negedge clk);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    phase = "R10 R7 before first frame";
    repeat (20) @(negedge clk);
    salt = 3;   phase = "R1 base rate";       run_frames(0, 2);
    phase = "R8 mid-frame mode write";
    frame_i = 1'b1; mode_i = 2'd0;
    @(negedge clk);
    frame_i = 1'b0;
    repeat (100) @(negedge clk);
    mode_i = 2'd1;
    repeat (155) @(negedge clk);
    salt = 17;  phase = "R2 double rate";     run_frames(1, 2);
    salt = 40;  phase = "R3 quad rate";       run_frames(2, 2);
    phase = "R5 free-running wrap";
    repeat (1024 + 300) @(negedge clk);
    phase = "R5 mid-slot frame pulse";        run_frames(0, 1);
    salt = 91;  phase = "R7 reserved mode";   run_frames(3, 2);
    salt = 5;   phase = "R1 recovery";        run_frames(0, 1);
    @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule